// File: doc/BRIEF.md
# Flash Parameter Record Slot Manager

This controller keeps a small parameter set in one erasable flash page. It does not erase the page on every update. Each update is appended as a new fixed-size record. A record holds the parameter bytes followed by one marker byte. An erased marker reads 0xFF, and a committed record has its marker programmed to 0x00. Slots are used in order from the lowest address of the page upward, so a page with eight slots takes eight updates between erases. A page erase is requested only when a save finds no free slot left. The new record then goes into slot 0.

The block drives a program/erase engine through a request/acknowledge handshake. The engine owns all flash timing. A local shadow copy of the parameters serves every read, so reads never touch flash. After reset the block reads all markers and recovers the newest committed record into the shadow copy. If no record is committed, the shadow copy is filled with 0xFF. The marker is the last byte written in a save, so a save that is cut short leaves the previous record as the newest valid one.

Top module: `flash_param_slots`

## Requirements
- R1: After reset `save_ready` stays low until recovery ends. Recovery loads the shadow copy from the highest-numbered slot whose marker reads 0x00. Slot s occupies page addresses 16*s to 16*s+15. Data byte i sits at offset i (i = 0..14) and the marker sits at offset 15. A slot that holds data bytes but whose marker is still 0xFF is not recovered.
- R2: If no marker reads 0x00 during recovery, every shadow byte reads 0xFF.
- R3: A save reads the markers of slots 0 to 7 in order. It then writes its 15 data bytes into the lowest-numbered slot whose marker reads 0xFF, even when a higher slot is already used.
- R4: Within a save, the marker program (value 0x00 at offset 15) is issued only after all 15 data-byte programs of that save have been acknowledged.
- R5: When no marker reads 0xFF, a save issues exactly one page erase and then writes its record into slot 0. After that save, slot 1's marker still reads 0xFF.
- R6: `rd_data` shows the shadow byte selected by `rd_idx` one clock after `rd_idx` is applied. After a save completes, the shadow bytes equal the saved data. Index 15 reads 0xFF.
- R7: A save is accepted only while `save_ready` is high. `save_ready` is low in the cycle after acceptance and stays low until the marker program is acknowledged. A `save_req` that arrives while `save_ready` is low has no effect on the flash or on the shadow copy.
- R8: `eng_req` is held, with `eng_op`, `eng_addr` and `eng_wdata` stable, until `eng_ack` is sampled high. It is low in the following cycle.
- R9: `eng_op` is encoded as 0 = read one byte (result on `eng_rdata` with `eng_ack`), 1 = program one byte, 2 = erase the page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_req | input | 1 | Request to store `save_data` as a new record |
| save_data | input | 120 | Parameter bytes; byte i is bits 8i+7..8i |
| save_ready | output | 1 | High when a save can be accepted |
| rd_idx | input | 4 | Shadow byte index to read |
| rd_data | output | 8 | Shadow byte, registered |
| eng_req | output | 1 | Engine operation request |
| eng_op | output | 2 | Engine operation code |
| eng_addr | output | 7 | Byte address within the page |
| eng_wdata | output | 8 | Byte to program |
| eng_ack | input | 1 | Engine completion pulse |
| eng_rdata | input | 8 | Byte read, valid with `eng_ack` |

## Verification
Shadow reads are due one clock after `rd_idx` changes. The bench applies the index at a falling edge and compares at the next falling edge. `save_ready` is due low one clock after the accepting edge, so the bench checks it at the first falling edge after it drops `save_req`.

Flash content and shadow values are only due once `save_ready` rises again. The number of cycles a save takes depends on the engine latency, which the bench model randomizes. For that reason every check that depends on a save waits for `save_ready` first. The bench then compares against its own copy of the page, using a first-free-slot function and a last-valid-slot function.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } fps_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_DECIDE,
    S_LOAD,
    S_FILL,
    S_ERASE,
    S_PROG,
    S_MARK
  } fps_state_e;

  localparam logic [7:0] BYTE_BLANK = 8'hFF;
  localparam logic [7:0] BYTE_USED  = 8'h00;
endpackage

// File: rtl/fps_scan_tracker.sv
module fps_scan_tracker #(
  parameter int SLOTS = 8,
  localparam int SLOTW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [SLOTW-1:0] slot,
  input  logic [7:0]       marker,
  output logic             free_found,
  output logic [SLOTW-1:0] free_slot,
  output logic             used_found,
  output logic [SLOTW-1:0] used_slot
);
  import fps_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      free_found <= 1'b0;
      free_slot  <= '0;
      used_found <= 1'b0;
      used_slot  <= '0;
    end else if (upd) begin
      if (marker == BYTE_BLANK && !free_found) begin
        free_found <= 1'b1;
        free_slot  <= slot;
      end
      if (marker == BYTE_USED) begin
        used_found <= 1'b1;
        used_slot  <= slot;
      end
    end
  end

  // R3: the first free slot, once found, is never replaced during the scan
  p_first_free_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (free_found && upd && !clr) |=> (free_found && $stable(free_slot)));

  p_upd_excl_clr_r3: assert property (@(posedge clk) disable iff (rst)
    upd |-> !clr);
endmodule

// File: rtl/fps_shadow.sv
module fps_shadow #(
  parameter int DEPTH = 15,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (int'(raddr) < DEPTH) rdata <= mem[raddr];
    else                     rdata <= 8'hFF;
  end

  // R6: only real parameter bytes are ever written
  p_wr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl #(
  parameter int SLOT_BYTES = 16,
  parameter int SLOTS      = 8,
  localparam int DBYTES = SLOT_BYTES - 1,
  localparam int PAGE   = SLOT_BYTES * SLOTS,
  localparam int ADDRW  = $clog2(PAGE),
  localparam int IDXW   = $clog2(SLOT_BYTES),
  localparam int SLOTW  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                save_req,
  input  logic [DBYTES*8-1:0] save_data,
  output logic                save_ready,
  output logic                eng_req,
  output logic [1:0]          eng_op,
  output logic [ADDRW-1:0]    eng_addr,
  output logic [7:0]          eng_wdata,
  input  logic                eng_ack,
  input  logic [7:0]          eng_rdata,
  output logic                trk_clr,
  output logic                trk_upd,
  output logic [SLOTW-1:0]    trk_slot,
  input  logic                free_found,
  input  logic [SLOTW-1:0]    free_slot,
  input  logic                used_found,
  input  logic [SLOTW-1:0]    used_slot,
  output logic                sh_we,
  output logic [IDXW-1:0]     sh_waddr,
  output logic [7:0]          sh_wdata
);
  import fps_pkg::*;

  fps_state_e          state_q;
  logic                boot_q;
  logic [SLOTW-1:0]    slot_q;
  logic [IDXW-1:0]     off_q;
  logic [DBYTES*8-1:0] stage_q;
  logic                ready_q;
  logic                req_q;
  fps_op_e             op_q;
  logic [ADDRW-1:0]    addr_q;
  logic [7:0]          wdata_q;
  logic                ack;
  logic                last_off;
  logic                accept;
  logic [7:0]          stage_byte;

  function automatic logic [ADDRW-1:0] slot_addr(input logic [SLOTW-1:0] s,
                                                 input int o);
    return ADDRW'(int'(s) * SLOT_BYTES + o);
  endfunction

  assign ack        = eng_ack && req_q;
  assign last_off   = (int'(off_q) == DBYTES - 1);
  assign accept     = (state_q == S_IDLE) && ready_q && save_req;
  assign stage_byte = stage_q[int'(off_q)*8 +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_SCAN;
      boot_q  <= 1'b1;
      slot_q  <= '0;
      off_q   <= '0;
      stage_q <= '0;
      ready_q <= 1'b0;
      req_q   <= 1'b0;
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            stage_q <= save_data;
            ready_q <= 1'b0;
            boot_q  <= 1'b0;
            slot_q  <= '0;
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (ack) begin
            req_q <= 1'b0;
            if (int'(slot_q) == SLOTS - 1) state_q <= S_DECIDE;
            else                           slot_q  <= slot_q + 1'b1;
          end else if (!req_q) begin
            req_q  <= 1'b1;
            op_q   <= OP_READ;
            addr_q <= slot_addr(slot_q, SLOT_BYTES - 1);
          end
        end
        S_DECIDE: begin
          off_q <= '0;
          if (boot_q) begin
            slot_q  <= used_slot;
            state_q <= used_found ? S_LOAD : S_FILL;
          end else if (free_found) begin
            slot_q  <= free_slot;
            state_q <= S_PROG;
          end else begin
            state_q <= S_ERASE;
          end
        end
        S_LOAD: begin
          if (ack) begin
            req_q <= 1'b0;
            if (last_off) begin
              state_q <= S_IDLE;
              ready_q <= 1'b1;
            end else begin
              off_q <= off_q + 1'b1;
            end
          end else if (!req_q) begin
            req_q  <= 1'b1;
            op_q   <= OP_READ;
            addr_q <= slot_addr(slot_q, int'(off_q));
          end
        end
        S_FILL: begin
          if (last_off) begin
            state_q <= S_IDLE;
            ready_q <= 1'b1;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        S_ERASE: begin
          if (ack) begin
            req_q   <= 1'b0;
            slot_q  <= '0;
            off_q   <= '0;
            state_q <= S_PROG;
          end else if (!req_q) begin
            req_q   <= 1'b1;
            op_q    <= OP_ERASE;
            addr_q  <= '0;
            wdata_q <= BYTE_BLANK;
          end
        end
        S_PROG: begin
          if (ack) begin
            req_q <= 1'b0;
            if (last_off) state_q <= S_MARK;
            else          off_q   <= off_q + 1'b1;
          end else if (!req_q) begin
            req_q   <= 1'b1;
            op_q    <= OP_PROG;
            addr_q  <= slot_addr(slot_q, int'(off_q));
            wdata_q <= stage_byte;
          end
        end
        S_MARK: begin
          if (ack) begin
            req_q   <= 1'b0;
            ready_q <= 1'b1;
            state_q <= S_IDLE;
          end else if (!req_q) begin
            req_q   <= 1'b1;
            op_q    <= OP_PROG;
            addr_q  <= slot_addr(slot_q, SLOT_BYTES - 1);
            wdata_q <= BYTE_USED;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    sh_we    = 1'b0;
    sh_waddr = off_q;
    sh_wdata = BYTE_BLANK;
    if (state_q == S_LOAD && ack) begin
      sh_we    = 1'b1;
      sh_wdata = eng_rdata;
    end else if (state_q == S_FILL) begin
      sh_we    = 1'b1;
    end else if (state_q == S_PROG && ack) begin
      sh_we    = 1'b1;
      sh_wdata = stage_byte;
    end
  end

  assign trk_clr    = accept;
  assign trk_upd    = (state_q == S_SCAN) && ack;
  assign trk_slot   = slot_q;
  assign save_ready = ready_q;
  assign eng_req    = req_q;
  assign eng_op     = op_q;
  assign eng_addr   = addr_q;
  assign eng_wdata  = wdata_q;

  // Checker state: data-byte program acks since acceptance, and an erase flag
  logic [IDXW:0] chk_data_acks;
  logic          chk_erased;
  always_ff @(posedge clk) begin
    if (rst || accept) begin
      chk_data_acks <= '0;
      chk_erased    <= 1'b0;
    end else if (eng_req && eng_ack) begin
      if (eng_op == OP_PROG && int'(eng_addr) % SLOT_BYTES != SLOT_BYTES - 1)
        chk_data_acks <= chk_data_acks + 1'b1;
      if (eng_op == OP_ERASE)
        chk_erased <= 1'b1;
    end
  end

  p_marker_after_data_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_op == OP_PROG && int'(eng_addr) % SLOT_BYTES == SLOT_BYTES - 1)
      |-> (int'(chk_data_acks) == DBYTES));

  p_erase_then_slot0_r5: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_op == OP_PROG && chk_erased) |-> (int'(eng_addr) < SLOT_BYTES));

  p_quiet_when_ready_r7: assert property (@(posedge clk) disable iff (rst)
    save_ready |-> !eng_req);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (save_ready && save_req) |=> !save_ready);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_addr) && $stable(eng_op)
                               && $stable(eng_wdata)));

  p_req_release_r8: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_ack) |=> !eng_req);

  p_op_legal_r9: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> (eng_op != 2'd3));
endmodule

// File: rtl/flash_param_slots.sv
module flash_param_slots #(
  parameter int SLOT_BYTES = 16,
  parameter int SLOTS      = 8,
  localparam int DBYTES = SLOT_BYTES - 1,
  localparam int PAGE   = SLOT_BYTES * SLOTS,
  localparam int ADDRW  = $clog2(PAGE),
  localparam int IDXW   = $clog2(SLOT_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                save_req,
  input  logic [DBYTES*8-1:0] save_data,
  output logic                save_ready,
  input  logic [IDXW-1:0]     rd_idx,
  output logic [7:0]          rd_data,
  output logic                eng_req,
  output logic [1:0]          eng_op,
  output logic [ADDRW-1:0]    eng_addr,
  output logic [7:0]          eng_wdata,
  input  logic                eng_ack,
  input  logic [7:0]          eng_rdata
);
  localparam int SLOTW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic             trk_clr, trk_upd;
  logic [SLOTW-1:0] trk_slot;
  logic             free_found, used_found;
  logic [SLOTW-1:0] free_slot, used_slot;
  logic             sh_we;
  logic [IDXW-1:0]  sh_waddr;
  logic [7:0]       sh_wdata;

  fps_ctrl #(.SLOT_BYTES(SLOT_BYTES), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst(rst),
    .save_req(save_req), .save_data(save_data), .save_ready(save_ready),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .trk_clr(trk_clr), .trk_upd(trk_upd), .trk_slot(trk_slot),
    .free_found(free_found), .free_slot(free_slot),
    .used_found(used_found), .used_slot(used_slot),
    .sh_we(sh_we), .sh_waddr(sh_waddr), .sh_wdata(sh_wdata)
  );

  fps_scan_tracker #(.SLOTS(SLOTS)) u_track (
    .clk(clk), .rst(rst), .clr(trk_clr), .upd(trk_upd),
    .slot(trk_slot), .marker(eng_rdata),
    .free_found(free_found), .free_slot(free_slot),
    .used_found(used_found), .used_slot(used_slot)
  );

  fps_shadow #(.DEPTH(DBYTES), .AW(IDXW)) u_shadow (
    .clk(clk), .rst(rst), .we(sh_we), .waddr(sh_waddr), .wdata(sh_wdata),
    .raddr(rd_idx), .rdata(rd_data)
  );
endmodule

// File: tb/flash_param_slots_bench.sv
module flash_param_slots_bench;
  localparam int SB = 16;
  localparam int NS = 8;
  localparam int DB = SB - 1;
  localparam int PG = SB * NS;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          save_req = 1'b0;
  logic [DB*8-1:0] save_data = '0;
  logic          save_ready;
  logic [3:0]    rd_idx = '0;
  logic [7:0]    rd_data;
  logic          eng_req;
  logic [1:0]    eng_op;
  logic [6:0]    eng_addr;
  logic [7:0]    eng_wdata;
  logic          eng_ack = 1'b0;
  logic [7:0]    eng_rdata = '0;

  always #2.5 clk = ~clk;

  flash_param_slots u_flash_param_slots (
    .clk(clk), .rst(rst), .save_req(save_req), .save_data(save_data),
    .save_ready(save_ready), .rd_idx(rd_idx), .rd_data(rd_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
  );

  // ---------------- flash page model behind the engine ----------------
  logic [7:0] mem    [PG];
  logic [7:0] pl_mem [PG];
  logic       pl_go = 1'b0;
  logic       busy = 1'b0;
  int         lat = 0;
  logic [6:0] start_addr;
  logic [1:0] start_op;
  int         n_erase = 0, n_prog = 0, data_run = 0;
  int         r4_bad = 0, r8_bad = 0, r9_bad = 0;

  always @(posedge clk) begin
    if (pl_go) begin
      for (int i = 0; i < PG; i++) mem[i] <= pl_mem[i];
    end
    if (rst) begin
      eng_ack <= 1'b0;
      busy    <= 1'b0;
    end else if (eng_ack) begin
      eng_ack <= 1'b0;
    end else if (busy) begin
      if (!eng_req || eng_addr != start_addr || eng_op != start_op) r8_bad <= r8_bad + 1;
      if (lat == 0) begin
        busy    <= 1'b0;
        eng_ack <= 1'b1;
        case (eng_op)
          2'd0: eng_rdata <= mem[eng_addr];
          2'd1: begin
            mem[eng_addr] <= mem[eng_addr] & eng_wdata;
            n_prog <= n_prog + 1;
            if (eng_addr[3:0] == 4'hF) begin
              if (data_run != DB) r4_bad <= r4_bad + 1;
              data_run <= 0;
            end else begin
              data_run <= data_run + 1;
            end
          end
          2'd2: begin
            for (int i = 0; i < PG; i++) mem[i] <= 8'hFF;
            n_erase <= n_erase + 1;
          end
          default: r9_bad <= r9_bad + 1;
        endcase
      end else begin
        lat <= lat - 1;
      end
    end else if (eng_req) begin
      busy       <= 1'b1;
      lat        <= int'($urandom_range(0, 3));
      start_addr <= eng_addr;
      start_op   <= eng_op;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [7:0] exp_sh [DB];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int first_free();
    for (int s = 0; s < NS; s++) if (mem[s*SB + SB-1] == 8'hFF) return s;
    return -1;
  endfunction

  function automatic int last_valid();
    int r = -1;
    for (int s = 0; s < NS; s++) if (mem[s*SB + SB-1] == 8'h00) r = s;
    return r;
  endfunction

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !save_ready; i++) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < DB; i++) begin
      @(negedge clk) rd_idx = 4'(i);
      @(negedge clk) chk(tag, rd_data, exp_sh[i]);
    end
  endtask

  task automatic preload(input int kind);
    for (int i = 0; i < PG; i++) pl_mem[i] = 8'hFF;
    if (kind == 1) begin
      // slots 0..4 committed, slot 5 holds data with a blank marker
      for (int s = 0; s < 6; s++) begin
        for (int i = 0; i < DB; i++) pl_mem[s*SB + i] = 8'((s*SB + i) ^ 8'h3C);
        if (s < 5) pl_mem[s*SB + SB-1] = 8'h00;
      end
    end else if (kind == 2) begin
      // slot 0 free, slot 1 committed
      for (int i = 0; i < DB; i++) pl_mem[SB + i] = 8'(8'hA0 + i);
      pl_mem[SB + SB-1] = 8'h00;
    end
    @(negedge clk) pl_go = 1'b1;
    @(negedge clk) pl_go = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", save_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready low during recovery", save_ready, 0);
    wait_ready();
  endtask

  task automatic do_save(input logic [DB*8-1:0] d, input bit poke);
    int slot, er0, pr0;
    slot = first_free();
    er0  = n_erase;
    pr0  = n_prog;
    wait_ready();
    @(negedge clk) begin save_req = 1'b1; save_data = d; end
    @(negedge clk) begin save_req = 1'b0; save_data = ~d; end
    chk("R7 ready drops after accept", save_ready, 0);
    if (poke) begin
      save_req = 1'b1;
      repeat (20) @(negedge clk);
      save_req = 1'b0;
    end
    wait_ready();
    @(negedge clk);
    for (int i = 0; i < DB; i++) exp_sh[i] = d[i*8 +: 8];
    if (slot < 0) begin
      chk("R5 one erase when full", n_erase - er0, 1);
      chk("R5 slot1 marker blank after erase", mem[SB + SB-1], 8'hFF);
      slot = 0;
    end else begin
      chk("R3 no erase when a slot is free", n_erase - er0, 0);
    end
    chk(poke ? "R7 busy request ignored, programs" : "R3 program count", n_prog - pr0, SB);
    chk("R3 marker committed", mem[slot*SB + SB-1], 8'h00);
    for (int i = 0; i < DB; i++)
      chk("R3 slot data", mem[slot*SB + i], d[i*8 +: 8]);
    read_all("R6 shadow after save");
  endtask

  function automatic logic [DB*8-1:0] rand_rec();
    logic [DB*8-1:0] r;
    for (int i = 0; i < DB; i++) r[i*8 +: 8] = 8'($urandom);
    return r;
  endfunction

  initial begin
    void'($urandom(32'h1F2E3D4C));
    preload(0);
    do_reset();
    for (int i = 0; i < DB; i++) exp_sh[i] = 8'hFF;
    read_all("R2 blank page recovers 0xFF");
    @(negedge clk) rd_idx = 4'd15;
    @(negedge clk) chk("R6 index 15 reads 0xFF", rd_data, 8'hFF);

    // fill the page; save 3 is hit by requests while busy
    for (int k = 0; k < NS; k++) begin
      do_save(rand_rec(), k == 2);
      chk("R3 slot order", last_valid(), k);
    end
    // page full: erase and slot 0 (R5)
    do_save(rand_rec(), 1'b0);
    chk("R5 record in slot 0", last_valid(), 0);

    // recovery of the latest record after reset (R1)
    do_reset();
    read_all("R1 recovery after reset");

    // interrupted save in slot 5: slot 4 must be recovered (R1)
    preload(1);
    do_reset();
    for (int i = 0; i < DB; i++) exp_sh[i] = 8'((4*SB + i) ^ 8'h3C);
    read_all("R1 interrupted save not recovered");

    // hole at slot 0: recover slot 1, next save goes into slot 0 (R3)
    preload(2);
    do_reset();
    for (int i = 0; i < DB; i++) exp_sh[i] = 8'(8'hA0 + i);
    read_all("R1 recover slot 1");
    do_save(rand_rec(), 1'b0);
    chk("R3 lowest blank slot chosen", mem[SB-1], 8'h00);

    // directed corner record of all zero and all one bytes
    do_save('0, 1'b0);
    do_save('1, 1'b0);

    chk("R4 marker after all data", r4_bad, 0);
    chk("R8 handshake held", r8_bad, 0);
    chk("R9 op codes legal", r9_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule